// File: doc/BRIEF.md
# Pulse-Swallow PLL Divider Chain

This block is the digital half of an integer-N frequency synthesizer. A feedback divider takes edges of the oscillator and produces one comparison pulse for every 32·M + S of them. It is built from a dual-modulus prescaler (divide by 32 or 33), a main counter and a swallow counter. A reference divider takes edges of the crystal reference and divides them by a small selectable ratio. A digital phase-frequency detector compares the two pulse trains and produces up and down outputs for an external charge pump. A lock detector watches how wide those outputs are. A status pin shows the lock indication or one of several test signals.

Both input rates arrive as single-cycle tick strobes on one fast sampling clock, so all of the logic is synchronous to `clk`. New divider codes can be written at any time. Each divider picks up its codes only at its own terminal count, so the output never produces a short cycle. While the PLL enable input is low, every counter, the detector and the lock state are held cleared, and the codes on the inputs are copied straight into the dividers.

Top module: `pswDivChain`

## Requirements
- R1: With every cycle carrying an oscillator tick, feedback pulses are one cycle wide and occur every 32·M + S cycles. M is 32 + `mainCode` (codes 0..3 give 32..35) and S is `swallowCode` (0..31).
- R2: A change to `mainCode`, `swallowCode` or `refCode` has no effect on the division period in progress. It applies from the period that starts at the next terminal count of that divider.
- R3: With a reference tick every cycle, reference pulses are one cycle wide and occur every 3, 4, 6 or 8 cycles for `refCode` 0, 1, 2 or 3.
- R4: `pfdUp` rises the cycle after a reference pulse and `pfdDn` rises the cycle after a feedback pulse. A line that is already high stays high. Both lines return low in the cycle after the opposite pulse arrives, and they are never high together.
- R5: A comparison ends when both pulses have been seen. Its width is the number of cycles `pfdUp` or `pfdDn` was high. A comparison is good when its width is strictly less than `lockTol`. Lock is reported only after 16 consecutive good comparisons.
- R6: The first comparison that is not good clears the lock indication and restarts the count of consecutive good comparisons.
- R7: `statusSel` picks the status output: 0 gives lock, 1 gives the reference pulse, 2 gives the feedback pulse, 3 gives the long test divider, 4 gives the half-rate test divider, and 5..7 give a constant 0.
- R8: The test dividers count reference pulses. Selection 4 toggles on every reference pulse, which divides the reference pulse rate by 2. Selection 3 toggles every 1024 reference pulses, which divides it by 2048.
- R9: While `pllEn` is low, `pfdUp`, `pfdDn`, the lock indication, both divider outputs and the test dividers are low from the next cycle onward.
- R10: During reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all logic |
| rstN | input | 1 | Asynchronous active-low reset |
| pllEn | input | 1 | Runs the dividers and detector while high, holds them cleared while low |
| vcoTick | input | 1 | One-cycle strobe per oscillator edge |
| refTick | input | 1 | One-cycle strobe per reference edge |
| mainCode | input | 2 | Main-counter code, M = 32 + code |
| swallowCode | input | 5 | Swallow count S |
| refCode | input | 2 | Reference ratio select (3/4/6/8) |
| lockTol | input | 10 | A comparison is good if its width is below this |
| statusSel | input | 3 | Status output select |
| pfdUp | output | 1 | Detector up output |
| pfdDn | output | 1 | Detector down output |
| statusOut | output | 1 | Lock indication or selected test signal |

## Verification
On every cycle the embedded properties check four things. Divider pulses are single-cycle. The up and down lines are never high together, and each rises only after its own divider pulse. Lock can only be raised by a good comparison. Holding `pllEn` low empties the detector, the lock state and the dividers by the next cycle. Some behaviour can only be shown by the bench's scenarios. These are the exact division periods for each code, the deferral of a code change to the next period, the lock count of exactly 16 and its restart, the tolerance boundary at width equal to `lockTol`, and the long 2048 test divider.

// File: rtl/pswPkg.sv
package pswPkg;

  // Code width of the reference ratio select
  localparam int REF_CODE_W = 2;
  // Counter width large enough for the largest reference ratio (8)
  localparam int REF_CNT_W  = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic count;   // advance counters
    logic flush;   // clear counters and reload codes
  } ctlStrb_t;

  typedef enum logic [2:0] {
    SEL_LOCK     = 3'd0,
    SEL_REF      = 3'd1,
    SEL_FB       = 3'd2,
    SEL_REF_LONG = 3'd3,
    SEL_REF_HALF = 3'd4
  } statSel_e;

  // Last count value of the reference divider for a ratio code
  function automatic logic [REF_CNT_W-1:0] refLastOf(input logic [REF_CODE_W-1:0] code);
    case (code)
      2'd0:    refLastOf = 3'd2;  // divide by 3
      2'd1:    refLastOf = 3'd3;  // divide by 4
      2'd2:    refLastOf = 3'd5;  // divide by 6
      default: refLastOf = 3'd7;  // divide by 8
    endcase
  endfunction

endpackage

// File: rtl/pswDivPath.sv
module pswDivPath
  import pswPkg::*;
#(
  parameter int PRE_BASE = 32,
  parameter int MC_W     = 2,
  parameter int SC_W     = 5,
  parameter int TST_LOG2 = 11
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrb_t              strb,
  input  logic                  vcoTick,
  input  logic                  refTick,
  input  logic [MC_W-1:0]       mainCode,
  input  logic [SC_W-1:0]       swallowCode,
  input  logic [REF_CODE_W-1:0] refCode,
  output logic                  fbPulse,
  output logic                  refPulse,
  output logic                  refLong,
  output logic                  refHalf
);

  localparam int PS_W     = $clog2(PRE_BASE + 1);
  localparam int MAIN_MAX = PRE_BASE + (1 << MC_W) - 1;
  localparam int MAIN_W   = $clog2(MAIN_MAX + 1);

  logic [PS_W-1:0]       psCnt;
  logic [MAIN_W-1:0]     mainCnt;
  logic [SC_W-1:0]       swRem;
  logic [MC_W-1:0]       mcAct;
  logic [REF_CODE_W-1:0] rcAct;
  logic [REF_CNT_W-1:0]  refCnt;
  logic [TST_LOG2-1:0]   tstCnt;

  logic [PS_W-1:0]      psLast;
  logic [MAIN_W-1:0]    mainLast;
  logic [REF_CNT_W-1:0] refLast;
  logic                 psWrap, fbTerm, refTerm;

  // Prescaler runs modulus PRE_BASE+1 while swallow count remains
  always_comb begin
    psLast   = (swRem != '0) ? PS_W'(PRE_BASE) : PS_W'(PRE_BASE - 1);
    psWrap   = vcoTick && (psCnt == psLast);
    mainLast = MAIN_W'(PRE_BASE - 1) + MAIN_W'(mcAct);
    fbTerm   = psWrap && (mainCnt == mainLast);
    refLast  = refLastOf(rcAct);
    refTerm  = refTick && (refCnt == refLast);
  end

  // Feedback divider: prescaler, main and swallow counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psCnt   <= '0;
      mainCnt <= '0;
      swRem   <= '0;
      mcAct   <= '0;
      fbPulse <= 1'b0;
    end else if (strb.flush) begin
      psCnt   <= '0;
      mainCnt <= '0;
      swRem   <= swallowCode;
      mcAct   <= mainCode;
      fbPulse <= 1'b0;
    end else if (strb.count) begin
      fbPulse <= fbTerm;
      if (vcoTick) psCnt <= psWrap ? '0 : psCnt + PS_W'(1);
      if (psWrap) begin
        if (fbTerm) begin
          mainCnt <= '0;
          swRem   <= swallowCode;
          mcAct   <= mainCode;
        end else begin
          mainCnt <= mainCnt + MAIN_W'(1);
          if (swRem != '0) swRem <= swRem - SC_W'(1);
        end
      end
    end
  end

  // Reference divider, codes latched at terminal count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCnt   <= '0;
      rcAct    <= '0;
      refPulse <= 1'b0;
    end else if (strb.flush) begin
      refCnt   <= '0;
      rcAct    <= refCode;
      refPulse <= 1'b0;
    end else if (strb.count) begin
      refPulse <= refTerm;
      if (refTick) begin
        if (refTerm) begin
          refCnt <= '0;
          rcAct  <= refCode;
        end else begin
          refCnt <= refCnt + REF_CNT_W'(1);
        end
      end
    end
  end

  // Test divider chain counting reference pulses
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            tstCnt <= '0;
    else if (strb.flush)  tstCnt <= '0;
    else if (strb.count && refPulse) tstCnt <= tstCnt + TST_LOG2'(1);
  end

  assign refHalf = tstCnt[0];
  assign refLong = tstCnt[TST_LOG2-1];

  // R1
  fb_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    fbPulse |=> !fbPulse);

  // R3
  ref_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    refPulse |=> !refPulse);

  // R9
  div_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> (!fbPulse && !refPulse && !refHalf && !refLong));

  // R1
  fb_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    fbPulse |-> (mainCnt == '0));

endmodule

// File: rtl/pswPfdCtl.sv
module pswPfdCtl
  import pswPkg::*;
#(
  parameter int TOL_W     = 10,
  parameter int LOCK_RUNS = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pllEn,
  input  logic             fbPulse,
  input  logic             refPulse,
  input  logic             refLong,
  input  logic             refHalf,
  input  logic [TOL_W-1:0] lockTol,
  input  logic [2:0]       statusSel,
  output ctlStrb_t         strb,
  output logic             pfdUp,
  output logic             pfdDn,
  output logic             statusOut
);

  localparam int RUN_W = $clog2(LOCK_RUNS + 1);

  logic [TOL_W-1:0] pw;
  logic [RUN_W-1:0] runCnt;
  logic             lockFlag;
  logic             setUp, setDn, evalNow, evalGood;
  logic [TOL_W:0]   widthNow;
  statSel_e         selNow;

  assign strb.count = pllEn;
  assign strb.flush = !pllEn;

  always_comb begin
    setUp    = pfdUp | refPulse;
    setDn    = pfdDn | fbPulse;
    evalNow  = setUp & setDn;
    widthNow = {1'b0, pw} + (TOL_W+1)'(pfdUp | pfdDn);
    evalGood = evalNow && (widthNow < {1'b0, lockTol});
  end

  // Phase-frequency detector with pulse-width measurement
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pfdUp <= 1'b0;
      pfdDn <= 1'b0;
      pw    <= '0;
    end else if (strb.flush) begin
      pfdUp <= 1'b0;
      pfdDn <= 1'b0;
      pw    <= '0;
    end else if (evalNow) begin
      pfdUp <= 1'b0;
      pfdDn <= 1'b0;
      pw    <= '0;
    end else begin
      pfdUp <= setUp;
      pfdDn <= setDn;
      if ((pfdUp | pfdDn) && (pw != '1)) pw <= pw + TOL_W'(1);
    end
  end

  // Lock detector: consecutive good comparisons
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt   <= '0;
      lockFlag <= 1'b0;
    end else if (strb.flush) begin
      runCnt   <= '0;
      lockFlag <= 1'b0;
    end else if (evalNow) begin
      if (evalGood) begin
        if (runCnt != RUN_W'(LOCK_RUNS)) runCnt <= runCnt + RUN_W'(1);
        if (runCnt >= RUN_W'(LOCK_RUNS - 1)) lockFlag <= 1'b1;
      end else begin
        runCnt   <= '0;
        lockFlag <= 1'b0;
      end
    end
  end

  // Status multiplexer
  assign selNow = statSel_e'(statusSel);
  always_comb begin
    case (selNow)
      SEL_LOCK:     statusOut = lockFlag;
      SEL_REF:      statusOut = refPulse;
      SEL_FB:       statusOut = fbPulse;
      SEL_REF_LONG: statusOut = refLong;
      SEL_REF_HALF: statusOut = refHalf;
      default:      statusOut = 1'b0;
    endcase
  end

  // R4
  pfd_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(pfdUp && pfdDn));

  // R4
  up_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pfdUp) |-> $past(refPulse));

  // R4
  dn_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pfdDn) |-> $past(fbPulse));

  // R5
  lock_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockFlag) |-> $past(evalGood));

  // R9
  pfd_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> (!pfdUp && !pfdDn && !lockFlag));

endmodule

// File: rtl/pswDivChain.sv
module pswDivChain
  import pswPkg::*;
#(
  parameter int PRE_BASE  = 32,
  parameter int MC_W      = 2,
  parameter int SC_W      = 5,
  parameter int TOL_W     = 10,
  parameter int LOCK_RUNS = 16,
  parameter int TST_LOG2  = 11
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  pllEn,
  input  logic                  vcoTick,
  input  logic                  refTick,
  input  logic [MC_W-1:0]       mainCode,
  input  logic [SC_W-1:0]       swallowCode,
  input  logic [REF_CODE_W-1:0] refCode,
  input  logic [TOL_W-1:0]      lockTol,
  input  logic [2:0]            statusSel,
  output logic                  pfdUp,
  output logic                  pfdDn,
  output logic                  statusOut
);

  ctlStrb_t strb;
  logic     fbPulse, refPulse, refLong, refHalf;

  pswDivPath #(
    .PRE_BASE(PRE_BASE), .MC_W(MC_W), .SC_W(SC_W), .TST_LOG2(TST_LOG2)
  ) u_path (
    .clk(clk), .rstN(rstN), .strb(strb),
    .vcoTick(vcoTick), .refTick(refTick),
    .mainCode(mainCode), .swallowCode(swallowCode), .refCode(refCode),
    .fbPulse(fbPulse), .refPulse(refPulse),
    .refLong(refLong), .refHalf(refHalf)
  );

  pswPfdCtl #(
    .TOL_W(TOL_W), .LOCK_RUNS(LOCK_RUNS)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .pllEn(pllEn),
    .fbPulse(fbPulse), .refPulse(refPulse),
    .refLong(refLong), .refHalf(refHalf),
    .lockTol(lockTol), .statusSel(statusSel),
    .strb(strb), .pfdUp(pfdUp), .pfdDn(pfdDn), .statusOut(statusOut)
  );

endmodule

// File: tb/pswDivChain_tb.sv
module pswDivChain_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pllEn = 1'b0;
  logic       vcoTick = 1'b1;
  logic       refTick = 1'b1;
  logic [1:0] mainCode = '0;
  logic [4:0] swallowCode = '0;
  logic [1:0] refCode = '0;
  logic [9:0] lockTol = '0;
  logic [2:0] statusSel = '0;
  logic       pfdUp, pfdDn, statusOut;

  int checks = 0;
  int fails  = 0;
  bit cmpOn  = 0;
  int refMode = 0;
  int tickPhase = 0;

  pswDivChain u_dut (
    .clk(clk), .rstN(rstN), .pllEn(pllEn), .vcoTick(vcoTick), .refTick(refTick),
    .mainCode(mainCode), .swallowCode(swallowCode), .refCode(refCode),
    .lockTol(lockTol), .statusSel(statusSel),
    .pfdUp(pfdUp), .pfdDn(pfdDn), .statusOut(statusOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference tick generator: every cycle, or one in 256 cycles
  always @(negedge clk) begin
    tickPhase <= tickPhase + 1;
    refTick   <= (refMode == 0) ? 1'b1 : ((tickPhase % 256) == 37);
  end

  // Behavioural reference model
  int mVc, mRc, mPw, mRun, mTst, mMc, mSc, mRcode, w;
  bit mUp, mDn, mFbP, mRefP, mLock, su, sd, nf, nr;

  function automatic int refRatio(input int code);
    case (code)
      0: return 3;
      1: return 4;
      2: return 6;
      default: return 8;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mVc = 0; mRc = 0; mPw = 0; mRun = 0; mTst = 0; mMc = 0; mSc = 0; mRcode = 0;
      mUp = 0; mDn = 0; mFbP = 0; mRefP = 0; mLock = 0;
    end else if (!pllEn) begin
      mVc = 0; mRc = 0; mPw = 0; mRun = 0; mTst = 0;
      mUp = 0; mDn = 0; mFbP = 0; mRefP = 0; mLock = 0;
      mMc = mainCode; mSc = swallowCode; mRcode = refCode;
    end else begin
      su = mUp | mRefP;
      sd = mDn | mFbP;
      if (su && sd) begin
        w = mPw + ((mUp | mDn) ? 1 : 0);
        if (w < int'(lockTol)) begin
          if (mRun < 16) mRun++;
          mLock = (mRun >= 16);
        end else begin
          mRun = 0; mLock = 0;
        end
        mUp = 0; mDn = 0; mPw = 0;
      end else begin
        if ((mUp | mDn) && mPw < 1023) mPw++;
        mUp = su; mDn = sd;
      end
      if (mRefP) mTst = (mTst + 1) % 2048;
      nf = 0;
      if (vcoTick) begin
        mVc++;
        if (mVc == 32 * (32 + mMc) + mSc) begin
          nf = 1; mVc = 0; mMc = mainCode; mSc = swallowCode;
        end
      end
      nr = 0;
      if (refTick) begin
        mRc++;
        if (mRc == refRatio(mRcode)) begin
          nr = 1; mRc = 0; mRcode = refCode;
        end
      end
      mFbP = nf; mRefP = nr;
    end
  end

  function automatic bit expStatus();
    case (statusSel)
      3'd0: return mLock;
      3'd1: return mRefP;
      3'd2: return mFbP;
      3'd3: return bit'((mTst >> 10) & 1);
      3'd4: return bit'(mTst & 1);
      default: return 1'b0;
    endcase
  endfunction

  // Cycle-by-cycle comparison against the model
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rstN && cmpOn) begin
      chk("R4 pfdUp vs model", int'(pfdUp), int'(mUp));
      chk("R4 pfdDn vs model", int'(pfdDn), int'(mDn));
      chk("R7 statusOut vs model", int'(statusOut), int'(expStatus()));
    end
  end

  task automatic waitPulse();
    do @(negedge clk); while (statusOut !== 1'b1);
  endtask

  task automatic countToNext(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (statusOut !== 1'b1);
  endtask

  task automatic highRun(output int n);
    do @(negedge clk); while (statusOut !== 1'b0);
    do @(negedge clk); while (statusOut !== 1'b1);
    n = 0;
    while (statusOut === 1'b1) begin n++; @(negedge clk); end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int n;
    int wd;
    bit seen;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 pfdUp in reset", int'(pfdUp), 0);
    chk("R10 pfdDn in reset", int'(pfdDn), 0);
    chk("R10 statusOut in reset", int'(statusOut), 0);
    rstN = 1'b1;
    cmpOn = 1'b1;
    repeat (2) @(negedge clk);

    // R1: feedback periods
    statusSel = 3'd2; refCode = 2'd1;
    pllEn = 1'b1;
    waitPulse();
    countToNext(n); chk("R1 period M32 S0", n, 1024);
    mainCode = 2'd2; swallowCode = 5'd7;
    countToNext(n); chk("R2 old codes hold", n, 1024);
    countToNext(n); chk("R1 period M34 S7", n, 1095);
    mainCode = 2'd3; swallowCode = 5'd31;
    countToNext(n); chk("R2 old codes hold", n, 1095);
    countToNext(n); chk("R1 period M35 S31", n, 1151);
    mainCode = 2'd1; swallowCode = 5'd0;
    countToNext(n);
    countToNext(n); chk("R1 period M33 S0", n, 1056);
    mainCode = 2'd0;

    // R3: reference ratios
    statusSel = 3'd1;
    for (int c = 0; c < 4; c++) begin
      waitPulse();
      refCode = 2'(c);
      countToNext(n);
      countToNext(n); chk("R3 reference ratio", n, refRatio(c));
    end

    // R8: test dividers
    refCode = 2'd0;
    pllEn = 1'b0; @(negedge clk); pllEn = 1'b1;
    statusSel = 3'd4;
    highRun(n); chk("R8 half-rate high run", n, 3);
    statusSel = 3'd3;
    highRun(n); chk("R8 long divider high run", n, 3072);

    // R7: unused selections
    for (int s = 5; s < 8; s++) begin
      statusSel = 3'(s);
      repeat (5) @(negedge clk);
      chk("R7 unused select is zero", int'(statusOut), 0);
    end

    // R9: disable clears everything
    statusSel = 3'd4;
    pllEn = 1'b0;
    @(negedge clk);
    chk("R9 pfdUp cleared", int'(pfdUp), 0);
    chk("R9 pfdDn cleared", int'(pfdDn), 0);
    chk("R9 half divider cleared", int'(statusOut), 0);
    statusSel = 3'd2;
    repeat (3) @(negedge clk);
    chk("R9 feedback idle", int'(statusOut), 0);

    // R5 / R6: lock detection
    mainCode = 2'd0; swallowCode = 5'd0; refCode = 2'd1;
    refMode = 1; lockTol = 10'd0; statusSel = 3'd0;
    @(negedge clk);
    pllEn = 1'b1;
    repeat (3000) @(negedge clk);
    wd = 0;
    while ((pfdUp | pfdDn) && wd < 1100) begin @(negedge clk); wd++; end
    seen = 0; wd = 0;
    while (!seen && wd < 1100) begin
      @(negedge clk); wd++;
      if (pfdUp | pfdDn) seen = 1;
    end
    n = 0;
    while (seen && (pfdUp | pfdDn)) begin n++; @(negedge clk); end
    chk("R6 no lock with zero tolerance", int'(statusOut), 0);
    lockTol = 10'(n + 1);
    repeat (10 * 1024) @(negedge clk);
    chk("R5 not locked before 16 comparisons", int'(statusOut), 0);
    repeat (8 * 1024) @(negedge clk);
    chk("R5 locked after 16 comparisons", int'(statusOut), 1);
    lockTol = 10'(n);
    repeat (1100) @(negedge clk);
    chk("R6 lock drops at width equal tolerance", int'(statusOut), 0);
    lockTol = 10'(n + 1);
    repeat (8 * 1024) @(negedge clk);
    chk("R5 count restarts after drop", int'(statusOut), 0);
    repeat (10 * 1024) @(negedge clk);
    chk("R5 relock after 16 more", int'(statusOut), 1);

    cmpOn = 1'b0;
    finishRun();
  end

endmodule